// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the receive-side byte queue of a 16550-style serial port. Received characters arrive as a one-cycle strobe with data, and they are held in a 16-entry circular queue. A host read strobe pops the oldest byte, and that byte is shown on the read-data output before the strobe. A control register write holds the enable bit, the flush commands and a two-bit trigger-level selector. The block reports the fill count, data-ready, trigger-reached, a sticky overrun flag and a one-cycle request to flush the transmit queue, which is handled elsewhere.

A character-timeout detector counts bit-time ticks while bytes wait in the queue. It fires after four character times pass with no byte arriving and no read. The length of one character comes from the line settings: one start bit, five to eight data bits, an optional parity bit, and one or two stop bits. When the enable bit is clear, the queue holds a single byte and the timeout stays idle.

Top module: `uart_rxq`

## Requirements
- R1: Accepted bytes are returned in arrival order. `rd_data_o` shows the oldest byte, `rd_i` pops it at the clock edge, and `count_o` tracks occupancy in the range 0..16.
- R2: When the queue is empty, `rd_data_o` is 0, and `rd_i` leaves the count at 0.
- R3: `data_ready_o` is 1 exactly when the queue holds at least one byte.
- R4: With enable (control bit 0) set, `trig_hit_o` is 1 when the count is at least the level selected by control bits 7:6. The encodings are 00=1, 01=4, 10=8 and 11=14.
- R5: With enable clear, the capacity is one byte, `trig_hit_o` equals `data_ready_o`, and `timeout_o` never sets.
- R6: A byte that arrives while the queue is at capacity is dropped and sets `overrun_o`. The flag stays set until the receive queue is flushed.
- R7: A control write with bit 1 set empties the receive queue and clears `timeout_o` and `overrun_o`.
- R8: A control write that sets bit 2, or that changes bit 0, pulses `tx_flush_o` for the following cycle. A change of bit 0 also flushes the receive queue as in R7.
- R9: Only control bits 7, 6, 3 and 0 (mask 0xC9) are kept and shown on `ctl_o`. A write whose value equals `ctl_o` has no effect at all.
- R10: The character length is 1 + (5 + lcr[1:0]) + lcr[3] + (lcr[2] ? 2 : 1) bits. With enable set and data waiting, `timeout_o` sets on the tick that completes 4 × that length ticks after the last reload.
- R11: Every accepted byte and every `rd_i` reloads the tick count to zero. `rd_i` also clears `timeout_o`. A reload in a cycle wins over a tick in the same cycle.
- R12: In a cycle where a control write flushes the receive queue, a received byte and a read in that same cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received-byte strobe |
| rx_data_i | input | DW (8) | Received byte |
| rd_i | input | 1 | Host read strobe, pops the oldest byte |
| ctl_we_i | input | 1 | Control register write |
| ctl_wdata_i | input | 8 | Control write data |
| lcr_i | input | 4 | Line settings: [1:0] data bits-5, [2] two stop bits, [3] parity |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_data_o | output | DW (8) | Oldest byte, or 0 when empty |
| count_o | output | CW (5) | Bytes held |
| data_ready_o | output | 1 | Queue not empty |
| trig_hit_o | output | 1 | Count reached trigger level |
| timeout_o | output | 1 | Character timeout pending |
| overrun_o | output | 1 | Sticky: byte dropped at capacity |
| ctl_o | output | 8 | Retained control bits |
| tx_flush_o | output | 1 | One-cycle transmit queue flush request |

## Verification
The bench drives the queue to 16 bytes and offers more, so the case of a full queue is reached. There, a design with an off-by-one capacity either keeps a seventeenth byte or drops the sixteenth, and the count and the overrun flag both show it. Timeout runs use the shortest frame (28 ticks) and the longest (48 ticks), with a byte pushed in the middle of the count. A design that miscounts the frame fires a tick early or late, and one that fails to reload fires too soon. Control writes that repeat the current value, that toggle the enable bit, or that land in the same cycle as a receive or a read are checked against flush priority. A wrong mask or a missing equality test shows up as a spurious flush or a changed `ctl_o`. Long random traffic under every trigger level checks that `trig_hit_o` follows the count exactly at the 1/4/8/14 thresholds.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int CTL_EN  = 0;
  localparam int CTL_RXF = 1;
  localparam int CTL_TXF = 2;
  localparam logic [7:0] CTL_KEEP = 8'hC9;
  localparam int MAX_FRAME = 12;

  typedef enum logic [1:0] {LVL_A = 2'd0, LVL_B = 2'd1, LVL_C = 2'd2, LVL_D = 2'd3} trig_sel_e;

  function automatic int trig_level(trig_sel_e s);
    case (s)
      LVL_A:   return 1;
      LVL_B:   return 4;
      LVL_C:   return 8;
      default: return 14;
    endcase
  endfunction

  // start + data + parity + stop
  function automatic int frame_bits(logic [3:0] lcr);
    return 1 + 5 + int'(lcr[1:0]) + int'(lcr[3]) + (lcr[2] ? 2 : 1);
  endfunction
endpackage

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl
  import uart_rxq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctl_o,
  output logic       rx_flush_o,
  output logic       tx_flush_o
);
  logic [7:0] ctl_q;
  logic       wr_eff, en_chg, tx_q;

  assign wr_eff     = we_i && (wdata_i != ctl_q);
  assign en_chg     = wdata_i[CTL_EN] ^ ctl_q[CTL_EN];
  assign rx_flush_o = wr_eff && (wdata_i[CTL_RXF] || en_chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= wr_eff && (wdata_i[CTL_TXF] || en_chg);
      if (wr_eff) ctl_q <= wdata_i & CTL_KEEP;
    end
  end

  assign ctl_o      = ctl_q;
  assign tx_flush_o = tx_q;
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata_o = (cnt != '0) ? mem[rd_ptr] : '0;
  assign count_o = cnt;
endmodule

// File: rtl/uart_rxq_tmo.sv
module uart_rxq_tmo #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          reload_i,
  input  logic          clr_i,
  input  logic          arm_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          pend_o
);
  logic [TW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (flush_i) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (reload_i) begin
      cnt <= '0;
      if (clr_i) pend <= 1'b0;
    end else if (arm_i && !pend && tick_i) begin
      if (cnt == limit_i - TW'(1)) begin
        cnt  <= '0;
        pend <= 1'b1;
      end else begin
        cnt <= cnt + TW'(1);
      end
    end
  end

  assign pend_o = pend;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CHARS = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rd_i,
  input  logic          ctl_we_i,
  input  logic [7:0]    ctl_wdata_i,
  input  logic [3:0]    lcr_i,
  input  logic          bit_tick_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          data_ready_o,
  output logic          trig_hit_o,
  output logic          timeout_o,
  output logic          overrun_o,
  output logic [7:0]    ctl_o,
  output logic          tx_flush_o
);
  localparam int TW = $clog2(CHARS * MAX_FRAME + 1);

  logic [7:0]    ctl;
  logic          rx_flush, en, push, pop, at_cap, ovr_q;
  logic [CW-1:0] cnt, cap, lvl;
  logic [TW-1:0] limit;

  uart_rxq_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .ctl_o      (ctl),
    .rx_flush_o (rx_flush),
    .tx_flush_o (tx_flush_o)
  );

  assign en     = ctl[CTL_EN];
  assign cap    = en ? CW'(DEPTH) : CW'(1);
  assign at_cap = (cnt >= cap);
  assign push   = rx_valid_i && !rx_flush && !at_cap;
  assign pop    = rd_i && !rx_flush && (cnt != '0);
  assign lvl    = CW'(trig_level(trig_sel_e'(ctl[7:6])));
  assign limit  = TW'(CHARS * frame_bits(lcr_i));

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (rx_data_i),
    .rdata_o (rd_data_o),
    .count_o (cnt)
  );

  uart_rxq_tmo #(.TW(TW)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (rx_flush),
    .reload_i (push || rd_i),
    .clr_i    (rd_i),
    .arm_i    (en && (cnt != '0)),
    .tick_i   (bit_tick_i),
    .limit_i  (limit),
    .pend_o   (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovr_q <= 1'b0;
    else if (rx_flush)               ovr_q <= 1'b0;
    else if (rx_valid_i && at_cap)   ovr_q <= 1'b1;
  end

  assign count_o      = cnt;
  assign data_ready_o = (cnt != '0);
  assign trig_hit_o   = en ? (cnt >= lvl) : (cnt != '0);
  assign overrun_o    = ovr_q;
  assign ctl_o        = ctl;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rd_i,
  input logic          ctl_we_i,
  input logic [7:0]    ctl_wdata_i,
  input logic [DW-1:0] rd_data_o,
  input logic [CW-1:0] count_o,
  input logic          timeout_o,
  input logic          overrun_o,
  input logic [7:0]    ctl_o,
  input logic          tx_flush_o
);
  logic [CW-1:0] cap_w;
  assign cap_w = ctl_o[0] ? CW'(DEPTH) : CW'(1);

  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  // R1
  push_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rd_i && !ctl_we_i && count_o < cap_w) |=> count_o == $past(count_o) + CW'(1));

  // R2
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_data_o == '0));

  // R5
  single_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[0] |-> (count_o <= CW'(1)));

  // R6
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !ctl_we_i && count_o == cap_w) |=> overrun_o);

  // R7
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[1] && ctl_wdata_i != ctl_o) |=> (count_o == '0 && !timeout_o && !overrun_o));

  // R9
  same_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i == ctl_o) |=> ($stable(ctl_o) && !tx_flush_o));

  // R10
  tmo_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (count_o != '0));

  // R11
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rd_i        (rd_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .rd_data_o   (rd_data_o),
  .count_o     (count_o),
  .timeout_o   (timeout_o),
  .overrun_o   (overrun_o),
  .ctl_o       (ctl_o),
  .tx_flush_o  (tx_flush_o)
);

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rd_i = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic [3:0] lcr_i = '0;
  logic       bit_tick_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [4:0] count_o;
  logic       data_ready_o, trig_hit_o, timeout_o, overrun_o, tx_flush_o;
  logic [7:0] ctl_o;

  always #4 clk_i = ~clk_i;

  uart_rxq u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [7:0] mq[$];
  logic [7:0] m_ctl = '0;
  bit m_tout = 0, m_ovr = 0, m_txf = 0;
  int m_tcnt = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic model_step();
    int cap, sz0, lim;
    bit flushed, pushd, popd, enchg, txn;
    cap = m_ctl[0] ? 16 : 1;
    lim = 4 * (1 + 5 + int'(lcr_i[1:0]) + int'(lcr_i[3]) + (lcr_i[2] ? 2 : 1));
    flushed = 0; txn = 0;
    if (ctl_we_i && ctl_wdata_i != m_ctl) begin
      enchg = ctl_wdata_i[0] != m_ctl[0];
      txn = ctl_wdata_i[2] || enchg;
      if (ctl_wdata_i[1] || enchg) begin
        mq.delete(); m_tout = 0; m_tcnt = 0; m_ovr = 0; flushed = 1;
      end
      m_ctl = ctl_wdata_i & 8'hC9;
    end
    if (!flushed) begin
      sz0 = mq.size();
      pushd = rx_valid_i && sz0 < cap;
      popd = rd_i && sz0 > 0;
      if (popd) void'(mq.pop_front());
      if (pushd) mq.push_back(rx_data_i);
      if (rx_valid_i && !pushd) m_ovr = 1;
      if (pushd || rd_i) begin
        m_tcnt = 0;
        if (rd_i) m_tout = 0;
      end else if (m_ctl[0] && sz0 > 0 && !m_tout && bit_tick_i) begin
        m_tcnt++;
        if (m_tcnt == lim) begin m_tout = 1; m_tcnt = 0; end
      end
    end
    m_txf = txn;
  endtask

  task automatic compare();
    int sz, expd, trig;
    sz = mq.size();
    expd = sz ? int'(mq[0]) : 0;
    trig = m_ctl[0] ? (sz >= lvl_of(m_ctl[7:6])) : (sz > 0);
    chk(count_o == 5'(sz), "R1 count", count_o, sz);
    chk(rd_data_o == 8'(expd), "R1/R2 rd_data", rd_data_o, expd);
    chk(data_ready_o == (sz > 0), "R3 data_ready", data_ready_o, sz > 0);
    chk(trig_hit_o == trig[0], "R4/R5 trig_hit", trig_hit_o, trig);
    chk(timeout_o == m_tout, "R10/R11 timeout", timeout_o, m_tout);
    chk(overrun_o == m_ovr, "R6 overrun", overrun_o, m_ovr);
    chk(ctl_o == m_ctl, "R9 ctl", ctl_o, m_ctl);
    chk(tx_flush_o == m_txf, "R8 tx_flush", tx_flush_o, m_txf);
  endtask

  task automatic cyc(bit rv, logic [7:0] rdv, bit rd, bit we, logic [7:0] wd, bit tk);
    rx_valid_i = rv; rx_data_i = rdv; rd_i = rd; ctl_we_i = we; ctl_wdata_i = wd; bit_tick_i = tk;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic push(logic [7:0] b);  cyc(1, b, 0, 0, 8'h00, 0); endtask
  task automatic pop();                cyc(0, 8'h00, 1, 0, 8'h00, 0); endtask
  task automatic wctl(logic [7:0] v);  cyc(0, 8'h00, 0, 1, v, 0);   endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 8'h00, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare();                        // reset state
    rst_ni = 1'b1;
    // R5: disabled single-byte mode, overrun on second byte
    push(8'hA1); push(8'hA2); ticks(40); pop(); pop();
    // R8/R7: enabling flushes and clears overrun
    wctl(8'h01);
    // R1: ordering
    for (int i = 0; i < 5; i++) push(8'(8'h10 + i));
    pop(); pop();
    // R6: fill past capacity
    for (int i = 0; i < 16; i++) push(8'(8'h30 + i));
    for (int i = 0; i < 18; i++) pop();  // R2 extra reads on empty
    // R9: same value, masked bits
    wctl(8'h01); wctl(8'h01); wctl(8'hFF); wctl(8'hC9); wctl(8'h37);
    wctl(8'h01);
    // R4: each level
    for (int l = 0; l < 4; l++) begin
      wctl(8'((l << 6) | 1));
      for (int i = 0; i < 15; i++) push(8'(i * 7));
      for (int i = 0; i < 15; i++) pop();
    end
    // R10: shortest and longest frame
    wctl(8'h01);
    lcr_i = 4'h0; push(8'h55); ticks(30); pop();
    lcr_i = 4'hF; push(8'h66); ticks(20); push(8'h67); ticks(50); pop(); ticks(50);
    // R11: reload wins over tick
    cyc(1, 8'h68, 0, 0, 8'h00, 1); cyc(0, 8'h00, 1, 0, 8'h00, 1);
    // R12: flush same cycle as receive and read
    push(8'h70);
    cyc(1, 8'h71, 1, 1, 8'h03, 1);
    // R8: tx flush only
    wctl(8'h05); wctl(8'h00); wctl(8'h01);
    // random traffic
    for (int n = 0; n < 5000; n++) begin
      bit we;
      logic [7:0] wd;
      we = ($urandom_range(99) < 2);
      wd = ($urandom_range(2) == 0) ? m_ctl : 8'($urandom);
      if ($urandom_range(3) != 0) wd[0] = 1'b1;
      if ($urandom_range(2) != 0) wd[1] = 1'b0;
      if ($urandom_range(99) == 0) lcr_i = 4'($urandom);
      cyc($urandom_range(99) < 35, 8'($urandom), $urandom_range(99) < 25, we, wd,
          $urandom_range(99) < 70);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule